// File: doc/BRIEF.md
# Toggle-Loop Event Synchronizer Bank

This block carries single-cycle events from a source clock domain into an unrelated destination clock domain. Each lane has one source-domain flip-flop that flips on every accepted event. A short flip-flop chain in the destination domain samples that flip-flop. Any change between the last two chain stages becomes a one-cycle enable in the destination domain. The source flip-flop loads the inverse of the first destination stage. This closes a feedback loop that contains one inverter, so the loop flips state once for each source event.

A lane works in one of two ways. A gated lane accepts an event only on source clock edges where its enable input is high. A free-running lane treats every source clock edge as an event, which carries the edges of the source clock itself into the destination domain. The detected change can be retimed through one extra destination flip-flop. This costs one cycle of latency and gives a glitch-free output. Any data that travels with an event must be held stable by its producer until the destination domain has used it on the generated enable. That holding register is not part of this block.

The destination clock must run faster than twice the rate of events on any lane. For a free-running lane, this means faster than twice the source clock. Bursts faster than that are outside the block's operating range.

Top module: `evsync_bank`

## Requirements
- R1: While the destination reset is asserted, every bit of `dst_evt` is 0. Both resets act asynchronously and clear every flip-flop of every lane.
- R2: On a gated lane, each source clock edge with the lane's `src_evt` bit high produces exactly one destination pulse, provided events are at least two source cycles apart.
- R3: On a gated lane, the source toggle flip-flop holds its value on every source edge where the lane's `src_evt` bit is 0. On a free-running lane (bit set in `FREE_RUN_MASK`), every source edge after reset is an event and the `src_evt` bit has no effect.
- R4: Every `dst_evt` pulse lasts exactly one destination clock cycle.
- R5: Latency is measured in destination rising edges, counting from the first one after the capturing source edge. The pulse is visible after edge number `SYNC_STAGES-1` for the direct output mode and after edge number `SYNC_STAGES` for the retimed mode.
- R6: After reset, a gated lane produces no pulse until its first source event. No lane ever produces more pulses than its source flip-flop has made changes.
- R7: Lanes are independent: an event on one lane produces pulses only on that lane's bit of `dst_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_evt | input | LANES | Per-lane event enable, sampled on `src_clk` rising edges (gated lanes only) |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_evt | output | LANES | Per-lane one-cycle event enable in the destination domain |

## Verification
The bench builds three lanes with a two-stage synchronizer, the retimed output and the top lane free-running. The two gated lanes are swept over every non-empty lane pattern and every event spacing from two to nine source cycles. The free-running lane covers carrying clock edges while its enable bit is toggled as noise. The destination clock has a 3 ns period and a fractional phase offset against the 8 ns source clock, so no two edges ever coincide. That fixes the latency of every pulse to an exact edge count, which the bench checks.

// File: rtl/evsync_pkg.sv
package evsync_pkg;

  // How the destination change detector drives the lane output.
  typedef enum logic {
    OUT_DIRECT  = 1'b0,  // XOR of the last two chain stages
    OUT_RETIMED = 1'b1   // XOR registered once more
  } out_mode_e;

  localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/evsync_src_cell.sv
module evsync_src_cell #(
  parameter bit FREE_RUN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic loop_back,   // first destination stage, fed back across domains
  output logic tog
);

  logic take;

  generate
    if (FREE_RUN) begin : g_free
      assign take = 1'b1;
    end else begin : g_gated
      assign take = evt;
    end
  endgenerate

  // One inverter in the loop: load the opposite of what the far side holds.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tog <= 1'b0;
    else if (take) tog <= ~loop_back;
  end

endmodule

// File: rtl/evsync_dst_cell.sv
module evsync_dst_cell
  import evsync_pkg::*;
#(
  parameter int        STAGES = 2,
  parameter out_mode_e MODE   = OUT_RETIMED
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic loop_tap,
  output logic pulse
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], tog_in};
  end

  assign loop_tap = chain[0];
  assign change   = chain[LAST] ^ chain[LAST-1];

  generate
    if (MODE == OUT_RETIMED) begin : g_retimed
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= change;
      end
      assign pulse = pulse_q;
    end else begin : g_direct
      assign pulse = change;
    end
  endgenerate

endmodule

// File: rtl/evsync_bank.sv
module evsync_bank
  import evsync_pkg::*;
#(
  parameter int               LANES         = 3,
  parameter int               SYNC_STAGES   = 2,
  parameter out_mode_e        OUT_MODE      = OUT_RETIMED,
  parameter logic [LANES-1:0] FREE_RUN_MASK = {1'b1, {(LANES-1){1'b0}}}
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic [LANES-1:0] src_evt,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [LANES-1:0] dst_evt
);

  localparam int STAGES_USED = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES
                                                                : SYNC_STAGES;

  logic [LANES-1:0] lane_tog;
  logic [LANES-1:0] lane_tap;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      evsync_src_cell #(
        .FREE_RUN (FREE_RUN_MASK[i])
      ) u_src (
        .clk       (src_clk),
        .rst_n     (src_rst_n),
        .evt       (src_evt[i]),
        .loop_back (lane_tap[i]),
        .tog       (lane_tog[i])
      );

      evsync_dst_cell #(
        .STAGES (STAGES_USED),
        .MODE   (OUT_MODE)
      ) u_dst (
        .clk      (dst_clk),
        .rst_n    (dst_rst_n),
        .tog_in   (lane_tog[i]),
        .loop_tap (lane_tap[i]),
        .pulse    (dst_evt[i])
      );
    end
  endgenerate

endmodule

// File: rtl/evsync_bank_chk.sv
module evsync_bank_chk #(
  parameter int               LANES         = 3,
  parameter logic [LANES-1:0] FREE_RUN_MASK = '0
) (
  input logic             src_clk,
  input logic             src_rst_n,
  input logic [LANES-1:0] src_evt,
  input logic             dst_clk,
  input logic             dst_rst_n,
  input logic [LANES-1:0] dst_evt,
  input logic [LANES-1:0] lane_tog
);

  // R1: output held low throughout destination reset
  always @(negedge dst_clk) begin
    if (!dst_rst_n) begin
      p_reset_quiet_r1: assert (dst_evt == '0)
        else $error("dst_evt active during reset");
    end
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_chk
      int   tog_cnt;
      int   pulse_cnt;
      logic tog_prev;
      int   tog_eff;

      always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
          tog_cnt  <= 0;
          tog_prev <= 1'b0;
        end else begin
          tog_prev <= lane_tog[i];
          if (lane_tog[i] != tog_prev) tog_cnt <= tog_cnt + 1;
        end
      end

      assign tog_eff = tog_cnt + int'(lane_tog[i] ^ tog_prev);

      always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n)      pulse_cnt <= 0;
        else if (dst_evt[i]) pulse_cnt <= pulse_cnt + 1;
      end

      // R4: a pulse never lasts a second cycle
      p_single_cycle_r4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_evt[i] |=> !dst_evt[i]);

      // R6: pulses never outnumber source toggles
      p_no_phantom_r6: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (pulse_cnt + int'(dst_evt[i])) <= tog_eff);

      if (!FREE_RUN_MASK[i]) begin : g_gated
        // R3: a gated lane's toggle holds without an event
        p_gated_hold_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
          !src_evt[i] |=> $stable(lane_tog[i]));
      end
    end
  endgenerate

endmodule

bind evsync_bank evsync_bank_chk #(
  .LANES         (LANES),
  .FREE_RUN_MASK (FREE_RUN_MASK)
) u_chk (
  .src_clk   (src_clk),
  .src_rst_n (src_rst_n),
  .src_evt   (src_evt),
  .dst_clk   (dst_clk),
  .dst_rst_n (dst_rst_n),
  .dst_evt   (dst_evt),
  .lane_tog  (lane_tog)
);

// File: tb/evsync_bank_tb.sv
`timescale 1ns/1ps
module evsync_bank_tb;
  import evsync_pkg::*;

  localparam int               LANES  = 3;
  localparam int               STAGES = 2;
  localparam out_mode_e        MODE   = OUT_RETIMED;
  localparam logic [LANES-1:0] FREE   = 3'b100;
  localparam int               LAT    = STAGES - 1 + ((MODE == OUT_RETIMED) ? 1 : 0);

  logic             src_clk = 1'b0;
  logic             dst_clk = 1'b0;
  logic             src_rst_n = 1'b0;
  logic             dst_rst_n = 1'b0;
  logic [LANES-1:0] src_evt = '0;
  logic [LANES-1:0] dst_evt;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // 125 MHz source clock; 3 ns destination clock with a fractional offset
  always #4 src_clk = ~src_clk;
  initial begin
    #0.7;
    forever begin
      dst_clk = ~dst_clk;
      #1.5;
    end
  end

  evsync_bank #(
    .LANES         (LANES),
    .SYNC_STAGES   (STAGES),
    .OUT_MODE      (MODE),
    .FREE_RUN_MASK (FREE)
  ) u_dut (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_evt   (src_evt),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_evt   (dst_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  // Reference bookkeeping: destination edges, source edges, pulses
  int   dst_edges = 0;
  int   src_edges = 0;
  int   stamp [2];
  int   pulses [LANES];
  logic prev_hi [LANES];

  always @(posedge dst_clk) dst_edges = dst_edges + 1;

  always @(posedge src_clk) begin
    if (!src_rst_n) src_edges = 0;
    else            src_edges = src_edges + 1;
    for (int i = 0; i < 2; i++)
      if (src_rst_n && src_evt[i]) stamp[i] = dst_edges;
  end

  initial for (int i = 0; i < LANES; i++) begin
    pulses[i]  = 0;
    prev_hi[i] = 1'b0;
  end

  always @(negedge dst_clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (dst_evt[i]) begin
        chk(!prev_hi[i], "R4 pulse width one cycle", 2, 1);
        pulses[i] = pulses[i] + 1;
        if (i < 2) chk((dst_edges - stamp[i]) == LAT, "R5 latency in dst edges",
                       dst_edges - stamp[i], LAT);
      end
      prev_hi[i] = dst_evt[i];
    end
  end

  int exp_cnt [2];

  task automatic zero_counts();
    for (int i = 0; i < LANES; i++) pulses[i] = 0;
    exp_cnt[0] = 0;
    exp_cnt[1] = 0;
  endtask

  task automatic reset_cycle();
    @(negedge src_clk);
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    src_evt   = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge dst_clk);
      chk(dst_evt == '0, "R1 outputs low in reset", int'(dst_evt), 0);
    end
    zero_counts();
    #1 dst_rst_n = 1'b1;
    @(negedge src_clk);
    src_rst_n = 1'b1;
    repeat (12) @(negedge src_clk);
    chk(pulses[0] == 0, "R6 lane0 quiet before first event", pulses[0], 0);
    chk(pulses[1] == 0, "R6 lane1 quiet before first event", pulses[1], 0);
  endtask

  task automatic free_lane_check();
    int e;
    @(negedge src_clk);
    e = src_edges;
    chk((pulses[2] <= e) && (pulses[2] >= e - 1), "R3 free-running lane follows src edges",
        pulses[2], e);
  endtask

  initial begin
    repeat (5) @(negedge src_clk);
    reset_cycle();

    // R2/R7: every lane pattern at every spacing; lane 2 enable toggled as noise
    for (int gap = 2; gap <= 9; gap++) begin
      for (int m = 1; m <= 3; m++) begin
        @(negedge src_clk);
        src_evt = {logic'(gap[0] ^ m[0]), logic'(m[1]), logic'(m[0])};
        exp_cnt[0] += m[0];
        exp_cnt[1] += m[1];
        @(negedge src_clk);
        src_evt[1:0] = 2'b00;
        repeat (gap - 1) @(negedge src_clk);
        chk(pulses[0] == exp_cnt[0], "R2 R7 lane0 pulse count", pulses[0], exp_cnt[0]);
        chk(pulses[1] == exp_cnt[1], "R2 R7 lane1 pulse count", pulses[1], exp_cnt[1]);
      end
    end

    // R3: long idle on gated lanes adds nothing
    src_evt = '0;
    repeat (20) @(negedge src_clk);
    chk(pulses[0] == exp_cnt[0], "R3 lane0 idle holds", pulses[0], exp_cnt[0]);
    chk(pulses[1] == exp_cnt[1], "R3 lane1 idle holds", pulses[1], exp_cnt[1]);
    free_lane_check();

    // Mid-run reset, then function again
    reset_cycle();
    @(negedge src_clk);
    src_evt[0] = 1'b1;
    @(negedge src_clk);
    src_evt[0] = 1'b0;
    repeat (3) @(negedge src_clk);
    chk(pulses[0] == 1, "R2 lane0 event after reset", pulses[0], 1);
    chk(pulses[1] == 0, "R7 lane1 untouched", pulses[1], 0);
    free_lane_check();

    summary();
  end

  initial begin
    #100000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

endmodule